// File: doc/BRIEF.md
# Selectable Bus Wait-State Generator

This block stretches bus I/O cycles that reach slow peripheral registers by holding an active-low ready line low for zero, one or two bus clocks. It watches a bus strobe, a board-select qualifier and a single address bit. When that bit is low, the access targets the slow register group. When it is high, the access targets fast local registers, which never wait. A two-bit configuration input chooses how many waits a slow access receives.

A short chain of stall flops advances on the bus clock while the strobe is active and clears on any clock where the strobe is idle. Each access therefore counts its waits from zero. Ready is released as soon as the stall stage picked by the configuration has set, and it stays released for the rest of the access. All of the block's pins are plain control signals. There is no data path and no handshake.

Top module: `ws_wait_gen`

## Requirements
- R1: After reset the stall chain is empty. With the strobe inactive, `rdy_n_o` is 1, and the first access after reset receives the full configured wait count.
- R2: With `wait_cfg_i` = 0, `rdy_n_o` is never driven low.
- R3: With `wait_cfg_i` = 1, a qualifying access holds `rdy_n_o` low from the moment the strobe goes active until the first rising clock edge. Only that single edge samples it low.
- R4: With `wait_cfg_i` = 2, a qualifying access holds `rdy_n_o` low across exactly the first two rising edges of the access.
- R5: A `wait_cfg_i` value above the supported maximum (code 3) behaves as the maximum, which is two waits.
- R6: An access with `addr_bit_i` = 1 (fast register) never drives `rdy_n_o` low.
- R7: An access with `board_sel_i` = 0 never drives `rdy_n_o` low.
- R8: While the strobe is inactive, `rdy_n_o` is 1 and the stall chain clears. An access that follows a single idle clock receives the full wait count again.
- R9: Once the wait count of an access has elapsed, `rdy_n_o` stays 1 for as long as the strobe remains active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the stall chain advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Bus strobe, high while an I/O access is in progress |
| board_sel_i | input | 1 | High when this board is addressed and its user group is selected |
| addr_bit_i | input | 1 | Register-class address bit: 0 = slow register, 1 = fast register |
| wait_cfg_i | input | 2 | Wait count: 0, 1 or 2; code 3 is treated as 2 |
| rdy_n_o | output | 1 | Active-low ready; 0 while a wait is being inserted |

## Verification
The bench measures how many clock edges each access spends with ready low, for every configuration code against slow, fast and unselected accesses. A wrong stage selection shows up as a count that is off by one, and a missing saturation of code 3 shows up as zero or stray waits. Short accesses that end before the wait count elapses, followed by a single idle clock, show whether the chain really clears. A chain that kept stale stages would give the next access fewer waits. Long accesses check that ready never drops again after release, which catches a chain that wraps or fails to hold its stages.

// File: rtl/ws_pkg.sv
package ws_pkg;
  // Width of the wait-count configuration field.
  localparam int WS_CFG_W = 2;
  typedef logic [WS_CFG_W-1:0] ws_cfg_t;
  // Named configuration codes.
  localparam ws_cfg_t WS_CFG_NONE = 2'd0;
  localparam ws_cfg_t WS_CFG_ONE  = 2'd1;
  localparam ws_cfg_t WS_CFG_TWO  = 2'd2;
endpackage

// File: rtl/ws_stall_chain.sv
module ws_stall_chain #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  output logic [DEPTH-1:0] stage_o
);
  // chain[0] is the strobe itself; chain[k] is stall stage k-1.
  logic [DEPTH:0] chain;
  assign chain[0] = strobe_i;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chain[k] <= 1'b0;
      else if (!strobe_i)
        chain[k] <= 1'b0;
      else
        chain[k] <= chain[k-1];
    end
  end

  assign stage_o = chain[DEPTH:1];
endmodule

// File: rtl/ws_wait_qual.sv
module ws_wait_qual
  import ws_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             strobe_i,
  input  logic             board_sel_i,
  input  logic             addr_bit_i,
  input  ws_cfg_t          wait_cfg_i,
  input  logic [DEPTH-1:0] stage_i,
  output logic             wait_o
);
  int   eff;
  logic reached;

  always_comb begin
    // Saturate the requested count to the depth of the chain.
    eff = (int'(wait_cfg_i) > DEPTH) ? DEPTH : int'(wait_cfg_i);
    reached = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (k == eff - 1) reached = stage_i[k];
    end
    wait_o = strobe_i & board_sel_i & ~addr_bit_i & ~reached;
  end
endmodule

// File: rtl/ws_wait_gen.sv
module ws_wait_gen
  import ws_pkg::*;
#(
  parameter int MAX_WAIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_i,
  input  logic                board_sel_i,
  input  logic                addr_bit_i,
  input  logic [WS_CFG_W-1:0] wait_cfg_i,
  output logic                rdy_n_o
);
  logic [MAX_WAIT-1:0] stage;
  logic                wait_act;

  ws_stall_chain #(.DEPTH(MAX_WAIT)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .stage_o  (stage)
  );

  ws_wait_qual #(.DEPTH(MAX_WAIT)) u_qual (
    .strobe_i    (strobe_i),
    .board_sel_i (board_sel_i),
    .addr_bit_i  (addr_bit_i),
    .wait_cfg_i  (wait_cfg_i),
    .stage_i     (stage),
    .wait_o      (wait_act)
  );

  // Ready is pulled low for as long as a wait is being inserted.
  assign rdy_n_o = ~wait_act;
endmodule

// File: rtl/ws_wait_gen_chk.sv
module ws_wait_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_i,
  input logic       board_sel_i,
  input logic       addr_bit_i,
  input logic [1:0] wait_cfg_i,
  input logic       rdy_n_o
);
  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |-> rdy_n_o);

  assert_zero_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cfg_i == 2'd0) |-> rdy_n_o);

  assert_fast_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bit_i |-> rdy_n_o);

  assert_unselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !board_sel_i |-> rdy_n_o);

  assert_first_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_i) && board_sel_i && !addr_bit_i && wait_cfg_i != 2'd0)
      |-> !rdy_n_o);

  assert_one_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && $past(strobe_i) && wait_cfg_i == 2'd1) |-> rdy_n_o);

  assert_second_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && $past(strobe_i) && !$past(strobe_i, 2) && board_sel_i &&
     !addr_bit_i && wait_cfg_i[1]) |-> !rdy_n_o);

  assert_release_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && $past(strobe_i) && $past(strobe_i, 2)) |-> rdy_n_o);
endmodule

bind ws_wait_gen ws_wait_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe_i    (strobe_i),
  .board_sel_i (board_sel_i),
  .addr_bit_i  (addr_bit_i),
  .wait_cfg_i  (wait_cfg_i),
  .rdy_n_o     (rdy_n_o)
);

// File: tb/ws_wait_gen_tb.sv
`timescale 1ns/1ps
module ws_wait_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic       sel = 1'b0;
  logic       abit = 1'b0;
  logic [1:0] cfg = 2'd0;
  logic       rdy_n;

  int n_checks = 0;
  int n_fail = 0;
  int model_cnt = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  ws_wait_gen u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .board_sel_i(sel),
    .addr_bit_i(abit), .wait_cfg_i(cfg), .rdy_n_o(rdy_n)
  );

  // Behavioural reference: edges elapsed since the strobe went active.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n || !strobe) model_cnt = 0;
    else if (model_cnt < 8) model_cnt++;
  end

  function automatic int eff_waits(input logic [1:0] c);
    return (c > 2'd2) ? 2 : int'(c);
  endfunction

  function automatic logic model_rdy_n();
    logic w;
    w = strobe && sel && !abit && (model_cnt < eff_waits(cfg));
    return !w;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison, sampled between the edges.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_checks++;
      if (rdy_n !== model_rdy_n()) begin
        n_fail++;
        $display("FAIL R2-R9 model: actual %0b expected %0b at %0t",
                 rdy_n, model_rdy_n(), $time);
      end
    end
  end

  // One access of hold clocks, followed by one idle clock; counts low edges.
  task automatic access(input string req, input logic [1:0] c, input logic s,
                        input logic a, input int hold);
    int lows = 0;
    int exp;
    @(negedge clk);
    cfg = c; sel = s; abit = a; strobe = 1'b1;
    for (int k = 0; k < hold; k++) begin
      #1;
      if (!rdy_n) lows++;
      @(negedge clk);
    end
    strobe = 1'b0;
    exp = (s && !a) ? eff_waits(c) : 0;
    if (exp > hold) exp = hold;
    n_checks++;
    if (lows != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d low clocks expected %0d (cfg %0d sel %0b bit %0b)",
               req, lows, exp, c, s, a);
    end
    #1;
    check(req, rdy_n, 1'b1); // idle: ready released
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", rdy_n, 1'b1);
    // R1: first access after reset gets the full count
    access("R1", 2'd2, 1'b1, 1'b0, 4);
    // R2: zero waits on every address class
    access("R2", 2'd0, 1'b1, 1'b0, 4);
    access("R2", 2'd0, 1'b1, 1'b1, 3);
    // R3: single wait
    access("R3", 2'd1, 1'b1, 1'b0, 4);
    access("R3", 2'd1, 1'b1, 1'b0, 1);
    // R4: two waits
    access("R4", 2'd2, 1'b1, 1'b0, 5);
    // R5: code 3 saturates to two
    access("R5", 2'd3, 1'b1, 1'b0, 5);
    // R6: fast registers never wait
    for (int c = 0; c < 4; c++) access("R6", 2'(c), 1'b1, 1'b1, 4);
    // R7: unselected board never waits
    for (int c = 0; c < 4; c++) access("R7", 2'(c), 1'b0, 1'b0, 4);
    // R8: short accesses back to back each restart the count
    access("R8", 2'd2, 1'b1, 1'b0, 1);
    access("R8", 2'd2, 1'b1, 1'b0, 3);
    access("R8", 2'd1, 1'b1, 1'b0, 1);
    access("R8", 2'd2, 1'b1, 1'b0, 2);
    // R9: long access keeps ready released after the waits
    access("R9", 2'd2, 1'b1, 1'b0, 12);
    access("R9", 2'd1, 1'b1, 1'b0, 10);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule